// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned W-bit operands over several clock cycles and returns their full 2W-bit product. It is intended for places where multiplications are rare enough that one partial product per cycle is acceptable. In exchange, the hardware is one W-bit adder and one 2W-bit working register instead of a full array.

A one-cycle `start` pulse while the block is idle captures both operands. The multiplier operand is placed in the low half of the working register, and the high half is cleared. On each following cycle the block examines the register's least significant bit. When that bit is 1, the captured multiplicand is added into the high half. In the same cycle the whole register, including the adder's carry-out, moves one place right. After W such steps `done` pulses for one cycle and the product is read from two halves, `prod_hi` and `prod_lo`. The product then holds until the next accepted start.

Top module: `seq_mul`

## Requirements
- R1: While `rst_n` is low, `busy`, `done`, `prod_hi` and `prod_lo` are all zero, and the reset takes effect without waiting for a clock edge.
- R2: A clock edge that samples `start` high while `busy` is low accepts the operands, and `busy` is high in the following cycle.
- R3: When `done` is high, `{prod_hi, prod_lo}` equals the unsigned product of the `mcand` and `mplier` values sampled at the accepting edge. `prod_hi` holds bits 2W-1..W and `prod_lo` holds bits W-1..0.
- R4: After an accepting edge, `busy` stays high for exactly W cycles. `done` rises in the cycle in which `busy` falls.
- R5: `done` is high for exactly one cycle per operation and is never high together with `busy`.
- R6: A `start` pulse while `busy` is high is ignored: neither the timing nor the result of the running operation changes.
- R7: While idle and `start` is low, `prod_hi` and `prod_lo` hold their value.
- R8: No carry is lost: all-ones times all-ones gives (2^W-1)^2. For W=4, 6×7 gives 8'b00101010 and 4×3 gives 8'b00001100.
- R9: A zero operand on either side gives a zero product.
- R10: Changes on `mcand` or `mplier` while `busy` is high have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, sampled while idle |
| mcand | input | W | Multiplicand operand |
| mplier | input | W | Multiplier operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking a valid product |
| prod_hi | output | W | Upper half of the product |
| prod_lo | output | W | Lower half of the product |

## Verification
A faulty step counter shows up as `done` arriving one cycle early or late. The bench exposes this by checking `busy` and `done` on every cycle of every run. A dropped carry, a wrong shift or a stale multiplicand corrupts the product, which is visible at the first `done` of an affected operand pair. The full 4-bit operand space is therefore run, together with all-ones cases. Wrong capture gating appears only when inputs move mid-run, so directed runs inject `start` and change operand values while `busy` is high.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [0:0] {
    MUL_IDLE = 1'b0,
    MUL_RUN  = 1'b1
  } mul_state_e;

  // width of a counter that must reach w-1
  function automatic int step_cnt_bits(input int w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction

endpackage

// File: rtl/mul_adder.sv
// W-bit adder with the carry kept as bit W; the addend is gated by add_en
module mul_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] addend,
  input  logic         add_en,
  output logic [W:0]   sum
);

  logic [W:0] addend_g;

  always_comb begin
    addend_g = add_en ? {1'b0, addend} : '0;
    sum      = {1'b0, acc} + addend_g;
  end

endmodule

// File: rtl/mul_ctrl.sv
// Sequencer: accepts start while idle, runs W steps, then pulses done
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  localparam int CW = step_cnt_bits(W);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  mul_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          last;
  logic          done_q, done_d;

  always_comb begin
    load   = (state_q == MUL_IDLE) && start;
    step   = (state_q == MUL_RUN);
    last   = step && (cnt_q == LAST_STEP);
    cnt_en = load || step;
    cnt_d  = load ? '0 : cnt_q + 1'b1;
    done_d = last;
    state_d = state_q;
    case (state_q)
      MUL_IDLE: if (start) state_d = MUL_RUN;
      MUL_RUN:  if (last)  state_d = MUL_IDLE;
      default:             state_d = MUL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MUL_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q == MUL_RUN);
  assign done = done_q;

endmodule

// File: rtl/mul_dpath.sv
// Shared product/multiplier register plus captured multiplicand
module mul_dpath #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);

  localparam int PW = 2 * W;

  logic [W-1:0]  mcand_q;
  logic [PW-1:0] prod_q, prod_d;
  logic          prod_en;
  logic [W:0]    sum;

  mul_adder #(.W(W)) adder_i (
    .acc    (prod_q[PW-1:W]),
    .addend (mcand_q),
    .add_en (prod_q[0]),
    .sum    (sum)
  );

  always_comb begin
    prod_en = load || step;
    prod_d  = prod_q;
    if (load) begin
      prod_d = {{W{1'b0}}, mplier};
    end else if (step) begin
      // carry lands in the top bit; lowest bit is retired
      prod_d = {sum, prod_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
    end else if (load) begin
      mcand_q <= mcand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (prod_en) begin
      prod_q <= prod_d;
    end
  end

  assign prod = prod_q;

endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);

  localparam int PW = 2 * W;

  logic          load;
  logic          step;
  logic [PW-1:0] prod;

  mul_ctrl #(.W(W)) ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  mul_dpath #(.W(W)) dpath_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (step),
    .mcand  (mcand),
    .mplier (mplier),
    .prod   (prod)
  );

  assign prod_hi = prod[PW-1:W];
  assign prod_lo = prod[W-1:0];

endmodule

// File: rtl/seq_mul_chk.sv
module seq_mul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] mcand,
  input logic [W-1:0] mplier,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo
);

  localparam int PW = 2 * W;

  logic [PW-1:0] exp_q;
  logic [31:0]   run_len;
  logic          accept;

  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q   <= '0;
      run_len <= '0;
    end else begin
      if (accept) begin
        exp_q   <= {{W{1'b0}}, mcand} * {{W{1'b0}}, mplier};
        run_len <= '0;
      end else if (busy) begin
        run_len <= run_len + 32'd1;
      end
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R3
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({prod_hi, prod_lo} == exp_q));

  // R4
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == 32'(W)));

  // R5
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({prod_hi, prod_lo}));

endmodule

bind seq_mul seq_mul_chk #(.W(W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .mcand   (mcand),
  .mplier  (mplier),
  .busy    (busy),
  .done    (done),
  .prod_hi (prod_hi),
  .prod_lo (prod_lo)
);

// File: tb/seq_mul_tb_top.sv
module seq_mul_tb_top;

  localparam int W  = 4;
  localparam int PW = 2 * W;
  localparam int NV = 8;
  // {mcand, mplier, expected product}
  localparam logic [W+W+PW-1:0] VEC [NV] = '{
    {4'd6,  4'd7,  8'b00101010},  // R8 worked example
    {4'd4,  4'd3,  8'b00001100},  // R8 worked example
    {4'd15, 4'd15, 8'd225},       // R8 carry out of adder
    {4'd0,  4'd9,  8'd0},         // R9
    {4'd11, 4'd0,  8'd0},         // R9
    {4'd1,  4'd15, 8'd15},
    {4'd8,  4'd8,  8'd64},
    {4'd10, 4'd5,  8'd50}
  };

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] mcand;
  logic [W-1:0] mplier;
  logic         busy;
  logic         done;
  logic [W-1:0] prod_hi;
  logic [W-1:0] prod_lo;

  int checks = 0;
  int errors = 0;

  seq_mul #(.W(W)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // mode 0: plain, 1: start pulse mid-run, 2: operand change mid-run
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input int mode, input string req);
    logic [PW-1:0] exp;
    exp = PW'(a) * PW'(b);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after accept", 64'(busy), 64'd1);
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      chk("R4 busy during run", 64'({busy, done}), 64'b10);
      if (i == 1 && mode == 1) begin start = 1'b1; mcand = ~a; mplier = ~b; end
      if (i == 1 && mode == 2) begin mcand = ~a; mplier = b + 1'b1; end
      if (i == 2) start = 1'b0;
    end
    @(negedge clk);
    chk("R4 done at step W", 64'(done), 64'd1);
    chk("R5 busy low with done", 64'(busy), 64'd0);
    chk(req, 64'({prod_hi, prod_lo}), 64'(exp));
  endtask

  initial begin
    logic [PW-1:0] held;
    rst_n = 1'b0; start = 1'b0; mcand = '0; mplier = '0;
    #1;
    // R1
    chk("R1 reset outputs", 64'({busy, done, prod_hi, prod_lo}), 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run(VEC[v][W+W+PW-1:W+PW], VEC[v][W+PW-1:PW], 0, "R3/R8/R9 table");
      chk("R3/R8/R9 table expected", 64'({prod_hi, prod_lo}), 64'(VEC[v][PW-1:0]));
    end

    // R8 and R9 directed
    run(4'hF, 4'hF, 0, "R8 all ones");
    run(4'h0, 4'h0, 0, "R9 both zero");

    // R6: start pulse while busy
    run(4'd13, 4'd11, 1, "R6 start ignored while busy");
    // R10: operand inputs move while busy
    run(4'd9, 4'd14, 2, "R10 operand change ignored");

    // R7: hold after done
    run(4'd7, 4'd12, 0, "R3 value");
    held = {prod_hi, prod_lo};
    repeat (3) @(negedge clk);
    chk("R7 product held while idle", 64'({prod_hi, prod_lo}), 64'(held));
    chk("R5 done single cycle", 64'({busy, done}), 64'd0);

    // R1: asynchronous reset mid-run
    start = 1'b1; mcand = 4'd5; mplier = 4'd6;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset mid-run", 64'({busy, done, prod_hi, prod_lo}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run(4'd5, 4'd6, 0, "R1 recovery after reset");

    // R3 exhaustive sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run(W'(a), W'(b), 0, "R3 sweep");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule